// File: doc/BRIEF.md
# Shared-Memory Four-Queue FIFO with Port-Side Queue Selection

This block holds several independent first-in first-out queues in one shared word memory. It runs on a single clock and has a write port and a read port. Each port keeps its own registered queue selection. A port loads a new selection from its queue-number bus on a clock edge where that port's select strobe is high. Writes and reads then go to whichever queue is selected on that port. Each queue owns a fixed region of the memory of equal size, with its own read pointer, write pointer and occupancy count.

Read data passes through a two-register output pipeline. An active-low valid flag travels with that pipeline, so the flag goes low exactly for the cycle in which a word that was actually read appears on the output. Two active-low status outputs report the occupancy of the currently selected queue on each port: almost-empty on the read side and almost-full on the write side. A one-cycle active-low queue-reset pulse empties one queue without touching the others. It acts only when both ports have that same queue selected.

Top module: `mq_fifo`

## Requirements
- R1: While master reset is asserted and afterwards, until a queue is selected on a port, that port has no queue selected. Writes and reads issued with no selection are ignored. `rdValidN`, `almostEmptyN` and `almostFullN` are all high after reset.
- R2: A port's selection changes only on an edge where its select strobe (`wrQueueLoad` / `rdQueueLoad`) is high. A read or write issued in a cycle uses the selection held before that cycle's edge. Changing the queue-number bus while the strobe is low has no effect.
- R3: Within each queue, words are read out in the order they were written. Traffic in one queue never alters another queue's contents.
- R4: A read accepted at edge k (`rdEnN` low, queue selected and not empty) puts its word on `rdData` with `rdValidN` low after edge k+1, for one cycle. In every other cycle `rdValidN` is high.
- R5: A read from an empty selected queue is ignored. No word is produced and `rdValidN` stays high.
- R6: A write to a full selected queue (count equal to the queue depth, 64 by default) is ignored. After writing more than 64 words and draining, exactly 64 words come out.
- R7: `almostEmptyN` is low exactly when a read queue is selected and its count is at most `AE_LEVEL` (8 by default).
- R8: `almostFullN` is low exactly when a write queue is selected and its count is at least `Q_DEPTH - AF_LEVEL` (56 by default).
- R9: With both ports selecting the same queue, a low `queueRstN` empties that queue at the edge: its pointers return to its first location and its count goes to zero. Any read or write in that cycle is ignored. Other queues are untouched.
- R10: A low `queueRstN` while the two ports select different queues, or while either port has no selection, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Master reset, active low, synchronous |
| wrQueue | input | 2 | Queue number for the write-port selection |
| wrQueueLoad | input | 1 | Loads `wrQueue` as the write selection |
| wrEnN | input | 1 | Write request, active low |
| wrData | input | 18 | Write data |
| rdQueue | input | 2 | Queue number for the read-port selection |
| rdQueueLoad | input | 1 | Loads `rdQueue` as the read selection |
| rdEnN | input | 1 | Read request, active low |
| queueRstN | input | 1 | Single-queue reset pulse, active low |
| rdData | output | 18 | Read data, second pipeline stage |
| rdValidN | output | 1 | Low when `rdData` holds a word that was read |
| almostEmptyN | output | 1 | Low when the selected read queue is almost empty |
| almostFullN | output | 1 | Low when the selected write queue is almost full |

## Verification
The hardest states to reach from the ports are a completely full queue and a single-queue reset taken while the two selections are aligned or deliberately misaligned. Random traffic rarely keeps one queue selected long enough to fill it, and it rarely lines up both selections at the moment of a reset pulse. Directed sequences therefore overfill one queue past its depth and drain it. They also pulse the queue reset once with mismatched selections and once with matched ones. A long random phase then mixes selection changes, reads, writes and reset pulses, and a cycle-accurate reference model in the bench checks the results.

// File: rtl/mq_pkg.sv
package mq_pkg;
  // Per-cycle strobes from control to datapath.
  typedef struct packed {
    logic wrFire;   // a write is accepted this cycle
    logic rdFire;   // a read is accepted this cycle
  } mqStrobeT;
endpackage

// File: rtl/mq_port_select.sv
module mq_port_select #(
  parameter int QW = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [QW-1:0] qIn,
  input  logic          load,
  output logic [QW-1:0] selQ,
  output logic          selValid
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      selQ     <= '0;
      selValid <= 1'b0;
    end else if (load) begin
      selQ     <= qIn;
      selValid <= 1'b1;
    end
  end
endmodule

// File: rtl/mq_control.sv
module mq_control
  import mq_pkg::*;
#(
  parameter int NUM_Q    = 4,
  parameter int Q_DEPTH  = 64,
  parameter int AE_LEVEL = 8,
  parameter int AF_LEVEL = 8,
  localparam int QW  = $clog2(NUM_Q),
  localparam int PW  = $clog2(Q_DEPTH),
  localparam int MAW = QW + PW
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [QW-1:0]  wrQueue,
  input  logic           wrQueueLoad,
  input  logic           wrEnN,
  input  logic [QW-1:0]  rdQueue,
  input  logic           rdQueueLoad,
  input  logic           rdEnN,
  input  logic           queueRstN,
  output mqStrobeT       strobe,
  output logic [MAW-1:0] wrAddr,
  output logic [MAW-1:0] rdAddr,
  output logic           almostEmptyN,
  output logic           almostFullN
);
  localparam int CW = PW + 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(Q_DEPTH);
  localparam logic [CW-1:0] AE_CNT   = CW'(AE_LEVEL);
  localparam logic [CW-1:0] AF_CNT   = CW'(Q_DEPTH - AF_LEVEL);

  logic [QW-1:0] wrSelQ, rdSelQ;
  logic          wrSelValid, rdSelValid;
  logic [PW-1:0] wrPtr [NUM_Q];
  logic [PW-1:0] rdPtr [NUM_Q];
  logic [CW-1:0] count [NUM_Q];
  logic          clearFire;

  mq_port_select #(.QW(QW)) i_wrSelect (
    .clk(clk), .rstN(rstN), .qIn(wrQueue), .load(wrQueueLoad),
    .selQ(wrSelQ), .selValid(wrSelValid)
  );

  mq_port_select #(.QW(QW)) i_rdSelect (
    .clk(clk), .rstN(rstN), .qIn(rdQueue), .load(rdQueueLoad),
    .selQ(rdSelQ), .selValid(rdSelValid)
  );

  // A single-queue reset needs both ports on the same queue.
  assign clearFire = !queueRstN && wrSelValid && rdSelValid && (wrSelQ == rdSelQ);

  always_comb begin
    strobe.wrFire = !clearFire && !wrEnN && wrSelValid && (count[wrSelQ] != FULL_CNT);
    strobe.rdFire = !clearFire && !rdEnN && rdSelValid && (count[rdSelQ] != '0);
    wrAddr = {wrSelQ, wrPtr[wrSelQ]};
    rdAddr = {rdSelQ, rdPtr[rdSelQ]};
    almostEmptyN = !(rdSelValid && (count[rdSelQ] <= AE_CNT));
    almostFullN  = !(wrSelValid && (count[wrSelQ] >= AF_CNT));
  end

  for (genvar q = 0; q < NUM_Q; q++) begin : g_queue
    localparam logic [QW-1:0] QID = QW'(q);
    logic incW, incR;
    assign incW = strobe.wrFire && (wrSelQ == QID);
    assign incR = strobe.rdFire && (rdSelQ == QID);

    always_ff @(posedge clk) begin
      if (!rstN || (clearFire && rdSelQ == QID)) begin
        wrPtr[q] <= '0;
        rdPtr[q] <= '0;
        count[q] <= '0;
      end else begin
        if (incW) wrPtr[q] <= wrPtr[q] + 1'b1;
        if (incR) rdPtr[q] <= rdPtr[q] + 1'b1;
        case ({incW, incR})
          2'b10:   count[q] <= count[q] + 1'b1;
          2'b01:   count[q] <= count[q] - 1'b1;
          default: count[q] <= count[q];
        endcase
      end
    end
  end
endmodule

// File: rtl/mq_datapath.sv
module mq_datapath
  import mq_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int MAW    = 8,
  localparam int WORDS = 1 << MAW
) (
  input  logic              clk,
  input  logic              rstN,
  input  mqStrobeT          strobe,
  input  logic [MAW-1:0]    wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [MAW-1:0]    rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValidN
);
  logic [DATA_W-1:0] mem [WORDS];
  logic [DATA_W-1:0] stage1Data, stage2Data;
  logic              stage1Valid, stage2Valid;

  always_ff @(posedge clk) begin
    if (strobe.wrFire) mem[wrAddr] <= wrData;
    if (strobe.rdFire) stage1Data <= mem[rdAddr];
    if (stage1Valid)   stage2Data <= stage1Data;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stage1Valid <= 1'b0;
      stage2Valid <= 1'b0;
    end else begin
      stage1Valid <= strobe.rdFire;
      stage2Valid <= stage1Valid;
    end
  end

  assign rdData   = stage2Data;
  assign rdValidN = !stage2Valid;
endmodule

// File: rtl/mq_fifo.sv
module mq_fifo
  import mq_pkg::*;
#(
  parameter int DATA_W   = 18,
  parameter int NUM_Q    = 4,
  parameter int Q_DEPTH  = 64,
  parameter int AE_LEVEL = 8,
  parameter int AF_LEVEL = 8,
  localparam int QW  = $clog2(NUM_Q),
  localparam int MAW = QW + $clog2(Q_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [QW-1:0]     wrQueue,
  input  logic              wrQueueLoad,
  input  logic              wrEnN,
  input  logic [DATA_W-1:0] wrData,
  input  logic [QW-1:0]     rdQueue,
  input  logic              rdQueueLoad,
  input  logic              rdEnN,
  input  logic              queueRstN,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValidN,
  output logic              almostEmptyN,
  output logic              almostFullN
);
  mqStrobeT       strobe;
  logic [MAW-1:0] wrAddr, rdAddr;

  mq_control #(
    .NUM_Q(NUM_Q), .Q_DEPTH(Q_DEPTH), .AE_LEVEL(AE_LEVEL), .AF_LEVEL(AF_LEVEL)
  ) i_control (
    .clk(clk), .rstN(rstN),
    .wrQueue(wrQueue), .wrQueueLoad(wrQueueLoad), .wrEnN(wrEnN),
    .rdQueue(rdQueue), .rdQueueLoad(rdQueueLoad), .rdEnN(rdEnN),
    .queueRstN(queueRstN), .strobe(strobe), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .almostEmptyN(almostEmptyN), .almostFullN(almostFullN)
  );

  mq_datapath #(.DATA_W(DATA_W), .MAW(MAW)) i_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr),
    .rdData(rdData), .rdValidN(rdValidN)
  );
endmodule

// File: rtl/mq_fifo_checker.sv
module mq_fifo_checker
  import mq_pkg::*;
(
  input logic     clk,
  input logic     rstN,
  input logic     rdEnN,
  input logic     rdValidN,
  input logic     almostEmptyN,
  input logic     almostFullN,
  input mqStrobeT strobe
);
  // An accepted read shows up as a valid word two edges later.
  assert_read_latency_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdFire |-> ##2 !rdValidN);

  // Every valid word traces back to an accepted read.
  assert_valid_has_source_R4: assert property (@(posedge clk) disable iff (!rstN)
    !rdValidN |-> $past(strobe.rdFire, 2));

  // No valid word without a read request at the port (empty reads produce nothing).
  assert_valid_needs_request_R5: assert property (@(posedge clk) disable iff (!rstN)
    !rdValidN |-> $past(!rdEnN, 2));

  // Right after master reset every flag is inactive.
  assert_reset_flags_R1: assert property (@(posedge clk) disable iff (!rstN)
    $past(!rstN) |-> (rdValidN && almostEmptyN && almostFullN));
endmodule

bind mq_fifo mq_fifo_checker i_checker (
  .clk(clk), .rstN(rstN), .rdEnN(rdEnN), .rdValidN(rdValidN),
  .almostEmptyN(almostEmptyN), .almostFullN(almostFullN), .strobe(strobe)
);

// File: tb/test_mq_fifo.sv
module test_mq_fifo;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  wrQueue = '0, rdQueue = '0;
  logic        wrQueueLoad = 1'b0, rdQueueLoad = 1'b0;
  logic        wrEnN = 1'b1, rdEnN = 1'b1, queueRstN = 1'b1;
  logic [17:0] wrData = '0;
  logic [17:0] rdData;
  logic        rdValidN, almostEmptyN, almostFullN;

  int checks = 0, errors = 0;
  bit finished = 0;

  // reference model
  logic [17:0] mdl [4][64];
  int mHead [4];
  int mCnt [4];
  int mWrQ, mRdQ;
  bit mWrV, mRdV;
  bit s1V;
  logic [17:0] s1D;
  bit expV;
  logic [17:0] expD;

  always #4 clk = ~clk;

  mq_fifo i_mq_fifo (
    .clk(clk), .rstN(rstN), .wrQueue(wrQueue), .wrQueueLoad(wrQueueLoad),
    .wrEnN(wrEnN), .wrData(wrData), .rdQueue(rdQueue), .rdQueueLoad(rdQueueLoad),
    .rdEnN(rdEnN), .queueRstN(queueRstN), .rdData(rdData), .rdValidN(rdValidN),
    .almostEmptyN(almostEmptyN), .almostFullN(almostFullN)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit expAe();
    return mRdV && (mCnt[mRdQ] <= 8);
  endfunction

  function automatic bit expAf();
    return mWrV && (mCnt[mWrQ] >= 56);
  endfunction

  // Drive one cycle at the falling edge, update the model, check after the next edge.
  task automatic step(input logic [1:0] wq, input logic ws, input logic we,
                      input logic [17:0] wd, input logic [1:0] rq, input logic rs,
                      input logic re, input logic prs);
    bit clr, wAcc, rAcc;
    logic [17:0] rv;
    wrQueue = wq; wrQueueLoad = ws; wrEnN = we; wrData = wd;
    rdQueue = rq; rdQueueLoad = rs; rdEnN = re; queueRstN = prs;
    clr  = !prs && mWrV && mRdV && (mWrQ == mRdQ);
    wAcc = !clr && !we && mWrV && (mCnt[mWrQ] < 64);
    rAcc = !clr && !re && mRdV && (mCnt[mRdQ] > 0);
    rv = '0;
    if (wAcc) mdl[mWrQ][(mHead[mWrQ] + mCnt[mWrQ]) % 64] = wd;
    if (rAcc) rv = mdl[mRdQ][mHead[mRdQ]];
    if (wAcc) mCnt[mWrQ]++;
    if (rAcc) begin
      mHead[mRdQ] = (mHead[mRdQ] + 1) % 64;
      mCnt[mRdQ]--;
    end
    if (clr) begin
      mHead[mRdQ] = 0;
      mCnt[mRdQ] = 0;
    end
    if (ws) begin mWrQ = int'(wq); mWrV = 1; end
    if (rs) begin mRdQ = int'(rq); mRdV = 1; end
    expV = s1V; expD = s1D;
    s1V = rAcc; s1D = rv;
    @(posedge clk);
    @(negedge clk);
    chk("R4 valid flag", {31'd0, rdValidN}, {31'd0, !expV});
    if (expV) chk("R3 read data order", {14'd0, rdData}, {14'd0, expD});
    chk("R7 almost empty", {31'd0, almostEmptyN}, {31'd0, !expAe()});
    chk("R8 almost full", {31'd0, almostFullN}, {31'd0, !expAf()});
  endtask

  task automatic idle();
    step(2'd0, 1'b0, 1'b1, 18'd0, 2'd0, 1'b0, 1'b1, 1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int validSeen;
    void'($urandom(32'd20240607));
    for (int q = 0; q < 4; q++) begin mHead[q] = 0; mCnt[q] = 0; end
    mWrV = 0; mRdV = 0; mWrQ = 0; mRdQ = 0; s1V = 0; s1D = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    chk("R1 valid after reset", {31'd0, rdValidN}, 32'd1);
    chk("R1 almost empty after reset", {31'd0, almostEmptyN}, 32'd1);
    chk("R1 almost full after reset", {31'd0, almostFullN}, 32'd1);

    // R1: traffic with no selection is ignored
    step(2'd0, 1'b0, 1'b0, 18'h111, 2'd0, 1'b0, 1'b0, 1'b1);
    step(2'd0, 1'b1, 1'b1, 18'd0, 2'd0, 1'b1, 1'b1, 1'b1);
    step(2'd0, 1'b0, 1'b1, 18'd0, 2'd0, 1'b0, 1'b0, 1'b1);
    idle();
    chk("R1 unselected write not stored", {31'd0, rdValidN}, 32'd1);

    // R5: reading the empty queue gives nothing
    for (int i = 0; i < 3; i++) step(2'd0, 1'b0, 1'b1, 18'd0, 2'd0, 1'b0, 1'b0, 1'b1);
    idle();
    chk("R5 empty read ignored", {31'd0, rdValidN}, 32'd1);

    // R6, R8: overfill queue 1
    step(2'd1, 1'b1, 1'b1, 18'd0, 2'd1, 1'b1, 1'b1, 1'b1);
    for (int i = 0; i < 66; i++)
      step(2'd1, 1'b0, 1'b0, 18'h1000 + 18'(i), 2'd1, 1'b0, 1'b1, 1'b1);
    chk("R8 full queue flag", {31'd0, almostFullN}, 32'd0);
    validSeen = 0;
    for (int i = 0; i < 70; i++) begin
      step(2'd1, 1'b0, 1'b1, 18'd0, 2'd1, 1'b0, 1'b0, 1'b1);
      if (!rdValidN) validSeen++;
    end
    idle();
    if (!rdValidN) validSeen++;
    chk("R6 words kept from overfill", 32'(validSeen), 32'd64);
    chk("R7 drained queue flag", {31'd0, almostEmptyN}, 32'd0);

    // R2: queue bus change without strobe is ignored
    for (int i = 0; i < 3; i++)
      step(2'd1, 1'b0, 1'b0, 18'h2000 + 18'(i), 2'd1, 1'b0, 1'b1, 1'b1);
    step(2'd1, 1'b0, 1'b1, 18'd0, 2'd3, 1'b0, 1'b0, 1'b1);
    idle();
    chk("R2 read stays on selected queue valid", {31'd0, rdValidN}, 32'd0);
    chk("R2 read stays on selected queue data", {14'd0, rdData}, 32'h2000);

    // R10: queue reset with differing selections has no effect
    step(2'd2, 1'b1, 1'b1, 18'd0, 2'd1, 1'b0, 1'b1, 1'b1);
    idle(); idle();
    step(2'd2, 1'b0, 1'b1, 18'd0, 2'd1, 1'b0, 1'b1, 1'b0);
    step(2'd2, 1'b0, 1'b1, 18'd0, 2'd1, 1'b0, 1'b0, 1'b1);
    idle();
    chk("R10 queue survives mismatched reset", {31'd0, rdValidN}, 32'd0);
    chk("R10 queue data intact", {14'd0, rdData}, 32'h2001);

    // R9: queue reset with matching selections empties the queue
    step(2'd1, 1'b1, 1'b1, 18'd0, 2'd1, 1'b0, 1'b1, 1'b1);
    idle(); idle();
    step(2'd1, 1'b0, 1'b0, 18'h3333, 2'd1, 1'b0, 1'b1, 1'b0);
    chk("R9 emptied queue almost empty", {31'd0, almostEmptyN}, 32'd0);
    step(2'd1, 1'b0, 1'b1, 18'd0, 2'd1, 1'b0, 1'b0, 1'b1);
    idle();
    chk("R9 read after queue reset", {31'd0, rdValidN}, 32'd1);

    // Random traffic against the model (R3, R4, R7, R8 every cycle)
    for (int i = 0; i < 4000; i++) begin
      step(2'($urandom_range(0, 3)), ($urandom_range(0, 7) == 0),
           ($urandom_range(0, 9) < 4), 18'($urandom),
           2'($urandom_range(0, 3)), ($urandom_range(0, 7) == 0),
           ($urandom_range(0, 9) < 5), ($urandom_range(0, 49) != 0));
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule